// File: doc/BRIEF.md
# Galois Field Log/Antilog Table Builder

This block fills two lookup memories for a binary extension field GF(2^m): an antilog table that maps an exponent i to the field element alpha^i, and a log table that maps a nonzero element back to its exponent. It is meant to run once before an error-correction decoder uses the tables. A single start pulse picks the field size from a sector-size input. A 512-byte sector selects m = 13 and a 1024-byte sector selects m = 14. The reduction polynomial comes in on its own input, normally 0x201B for m = 13 and 0x4443 for m = 14.

The builder begins at x = 1 and writes one antilog/log entry pair each clock. It then multiplies x by alpha: a left shift, followed by an XOR with the polynomial when bit m becomes set. Before the walk starts it rejects a polynomial whose top set bit is not bit m. During the walk it stops if x comes back to 1 early, which means the polynomial is not primitive. Both outcomes raise done together with an error flag. Once the build is over, the tables can be read through a lookup port with one cycle of latency.

Top module: `gf_table_gen`

## Requirements
- R1: After synchronous reset, busy, done, err_degree, err_nonprim and rd_valid are all 0.
- R2: sector_1k = 0 at the accepted start selects m = 13 and sector_1k = 1 selects m = 14. A good build raises done exactly 2^m + 1 clock edges after the edge that accepts start, with both error flags low.
- R3: For 0 <= i <= 2^m - 2, antilog entry i equals alpha^i. Here alpha^0 = 1, and each step shifts left by one bit and XORs the polynomial when bit m is set.
- R4: For 0 <= i <= 2^m - 2, the log entry at address alpha^i holds i.
- R5: After a good build, antilog entry 2^m - 1 holds 1 and log entry 0 holds 0.
- R6: If the highest set bit of poly is not bit m, err_degree and done rise 1 edge after the accepting edge, and no table walk runs.
- R7: If x returns to 1 at some step i > 0, err_nonprim and done rise on the next edge. For poly 0x2001 with m = 13 this happens at i = 13, which is 15 edges after the accepting edge.
- R8: After done, a read with rd_en = 1 returns rd_valid = 1 and rd_data on the following cycle. rd_sel = 0 reads the antilog table and rd_sel = 1 reads the log table, both at rd_addr.
- R9: A read request while busy is ignored: rd_valid stays 0.
- R10: A start pulse while busy is ignored, and so is any change of sector_1k or poly at that time. The build finishes on its original schedule with its original field.
- R11: Synchronous reset clears done and both error flags after a failed build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a build (accepted only when idle) |
| sector_1k | input | 1 | 0: 512-byte sector, m = 13; 1: 1024-byte sector, m = 14 |
| poly | input | 15 | Reduction polynomial, bit k is the x^k coefficient |
| busy | output | 1 | A build is in progress |
| done | output | 1 | Last build finished (good or failed) |
| err_degree | output | 1 | Polynomial degree differs from m |
| err_nonprim | output | 1 | Polynomial is not primitive |
| rd_en | input | 1 | Lookup request |
| rd_sel | input | 1 | 0: antilog table, 1: log table |
| rd_addr | input | 14 | Lookup address |
| rd_valid | output | 1 | rd_data holds the answer to last cycle's request |
| rd_data | output | 14 | Lookup result |

## Verification
The builder is run with both standard polynomials, one per field size, so the m = 13 and m = 14 walks and their exact build lengths can be told apart. Fixed table entries (alpha^0, alpha^m, the wrap entry and log of 0) are read, together with seeded random exponents checked in both directions through the antilog and log tables. A wrong shift or a wrong reduction shows up as a mismatch with the bench's own field arithmetic. A polynomial of the wrong degree and a degree-correct but reducible polynomial (x^13 + 1) separate the two error paths by flag and by timing. Starts and reads injected mid-build show that busy-time requests leave the schedule and the lookup port untouched.

// File: rtl/gf_tbl_pkg.sv
package gf_tbl_pkg;
    localparam int M_SMALL = 13;
    localparam int M_LARGE = 14;
    localparam int MAX_M   = M_LARGE;
    localparam int POLY_W  = MAX_M + 1;
    localparam int DEPTH   = 1 << MAX_M;

    typedef logic [MAX_M-1:0]  elem_t;
    typedef logic [POLY_W-1:0] poly_t;
    typedef logic [3:0]        deg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_BUILD,
        ST_FINISH
    } gen_state_e;

    typedef struct packed {
        logic  en;
        elem_t alog_addr;
        elem_t alog_data;
        elem_t log_addr;
        elem_t log_data;
    } tbl_wr_t;

    // Multiply a field element by alpha modulo the given polynomial.
    function automatic elem_t times_alpha(elem_t x, poly_t p, deg_t m);
        poly_t sh;
        sh = {x, 1'b0};
        if (sh[m]) sh = sh ^ p;
        return sh[MAX_M-1:0];
    endfunction
endpackage

// File: rtl/gf_poly_check.sv
module gf_poly_check
    import gf_tbl_pkg::*;
(
    input  poly_t poly,
    input  deg_t  m,
    output logic  deg_ok
);
    logic above;

    always_comb begin
        above = 1'b0;
        for (int b = 0; b < POLY_W; b++) begin
            if (b > int'(m) && poly[b]) above = 1'b1;
        end
        deg_ok = poly[m] && !above;
    end
endmodule

// File: rtl/gf_gen_ctrl.sv
module gf_gen_ctrl
    import gf_tbl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    sector_1k,
    input  poly_t   poly,
    output logic    busy,
    output logic    done,
    output logic    err_degree,
    output logic    err_nonprim,
    output tbl_wr_t wr
);
    gen_state_e state;
    logic       large_r;
    poly_t      poly_r;
    elem_t      x_r;
    elem_t      idx_r;
    deg_t       m_cur;
    poly_t      field_size;
    elem_t      last_idx;
    elem_t      wrap_idx;
    logic       deg_ok;
    logic       cycle_hit;

    assign m_cur      = large_r ? deg_t'(M_LARGE) : deg_t'(M_SMALL);
    assign field_size = poly_t'(1) << m_cur;
    assign last_idx   = field_size[MAX_M-1:0] - elem_t'(2);
    assign wrap_idx   = field_size[MAX_M-1:0] - elem_t'(1);
    assign cycle_hit  = (idx_r != '0) && (x_r == elem_t'(1));
    assign busy       = (state != ST_IDLE);

    gf_poly_check u_check (
        .poly   (poly_r),
        .m      (m_cur),
        .deg_ok (deg_ok)
    );

    always_comb begin
        wr = '0;
        if (state == ST_BUILD && !cycle_hit) begin
            wr.en        = 1'b1;
            wr.alog_addr = idx_r;
            wr.alog_data = x_r;
            wr.log_addr  = x_r;
            wr.log_data  = idx_r;
        end else if (state == ST_FINISH) begin
            wr.en        = 1'b1;
            wr.alog_addr = wrap_idx;
            wr.alog_data = elem_t'(1);
            wr.log_addr  = '0;
            wr.log_data  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            done        <= 1'b0;
            err_degree  <= 1'b0;
            err_nonprim <= 1'b0;
            large_r     <= 1'b0;
            poly_r      <= '0;
            x_r         <= '0;
            idx_r       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_CHECK;
                        large_r     <= sector_1k;
                        poly_r      <= poly;
                        done        <= 1'b0;
                        err_degree  <= 1'b0;
                        err_nonprim <= 1'b0;
                    end
                end
                ST_CHECK: begin
                    if (!deg_ok) begin
                        err_degree <= 1'b1;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_BUILD;
                        x_r   <= elem_t'(1);
                        idx_r <= '0;
                    end
                end
                ST_BUILD: begin
                    if (cycle_hit) begin
                        err_nonprim <= 1'b1;
                        done        <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        x_r   <= times_alpha(x_r, poly_r, m_cur);
                        idx_r <= idx_r + elem_t'(1);
                        if (idx_r == last_idx) state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_busy_not_done_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_err_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_degree, err_nonprim}));

    p_err_has_done_r7: assert property (@(posedge clk) disable iff (rst)
        (err_degree || err_nonprim) |-> done);

    p_index_steps_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUILD && $past(state) == ST_BUILD) |-> idx_r == $past(idx_r) + elem_t'(1));

    p_field_held_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(large_r) && $stable(poly_r));
endmodule

// File: rtl/gf_table_mem.sv
module gf_table_mem
    import gf_tbl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tbl_wr_t wr,
    input  logic    busy,
    input  logic    rd_en,
    input  logic    rd_sel,
    input  elem_t   rd_addr,
    output logic    rd_valid,
    output elem_t   rd_data
);
    localparam int NBANK = 2;

    elem_t bank_q [NBANK];
    logic  rd_fire;
    logic  sel_q;

    assign rd_fire = rd_en && !busy;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        elem_t mem [DEPTH];
        elem_t q;
        elem_t w_addr;
        elem_t w_data;

        if (g == 0) begin : g_alog
            assign w_addr = wr.alog_addr;
            assign w_data = wr.alog_data;
        end else begin : g_log
            assign w_addr = wr.log_addr;
            assign w_data = wr.log_data;
        end

        always_ff @(posedge clk) begin
            if (wr.en) mem[w_addr] <= w_data;
            if (rd_fire) q <= mem[rd_addr];
        end

        assign bank_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) sel_q <= rd_sel;
        end
    end

    assign rd_data = bank_q[sel_q];

    p_valid_after_req_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en) && !$past(busy));

    p_busy_read_dropped_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) |=> !rd_valid);
endmodule

// File: rtl/gf_table_gen.sv
module gf_table_gen
    import gf_tbl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        sector_1k,
    input  logic [14:0] poly,
    output logic        busy,
    output logic        done,
    output logic        err_degree,
    output logic        err_nonprim,
    input  logic        rd_en,
    input  logic        rd_sel,
    input  logic [13:0] rd_addr,
    output logic        rd_valid,
    output logic [13:0] rd_data
);
    tbl_wr_t wr;

    gf_gen_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sector_1k   (sector_1k),
        .poly        (poly),
        .busy        (busy),
        .done        (done),
        .err_degree  (err_degree),
        .err_nonprim (err_nonprim),
        .wr          (wr)
    );

    gf_table_mem u_mem (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .busy     (busy),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !done && !busy && !rd_valid && !err_degree && !err_nonprim);
endmodule

// File: tb/tb_gf_table_gen.sv
module tb_gf_table_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sector_1k = 1'b0;
    logic [14:0] poly = '0;
    logic        busy, done, err_degree, err_nonprim;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [13:0] rd_addr = '0;
    logic        rd_valid;
    logic [13:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    gf_table_gen dut (
        .clk(clk), .rst(rst), .start(start), .sector_1k(sector_1k), .poly(poly),
        .busy(busy), .done(done), .err_degree(err_degree), .err_nonprim(err_nonprim),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int alpha_pow(int m, int p, int e);
        int x = 1;
        for (int k = 0; k < e; k++) begin
            x = x << 1;
            if (((x >> m) & 1) == 1) x = x ^ p;
        end
        return x;
    endfunction

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, actual, actual, expected, expected);
        end
    endtask

    task automatic lookup(input bit sel, input int addr, output int data, output bit valid);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_sel  = sel;
        rd_addr = 14'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        valid = rd_valid;
        data  = int'(rd_data);
    endtask

    // Runs one build; returns edges from the accepting edge (=1) to done seen.
    task automatic run_build(input bit s1k, input int p, input bit inject, output int n);
        n = 0;
        @(negedge clk);
        sector_1k = s1k;
        poly      = 15'(p);
        start     = 1'b1;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (inject && n == 100) begin
                start     = 1'b1;
                sector_1k = ~s1k;
                poly      = 15'h7FFF;
            end
            if (inject && n == 200) begin
                check("R10 busy mid-build", int'(busy), 1);
                rd_en = 1'b1;
                rd_sel = 1'b0;
                rd_addr = 14'd0;
            end
            if (inject && n == 201) begin
                rd_en = 1'b0;
                check("R9 read ignored while busy", int'(rd_valid), 0);
            end
            if (done) break;
        end
        sector_1k = 1'b0;
        poly      = '0;
    endtask

    task automatic table_checks(int m, int p, string tag, int nrand);
        int d;
        bit v;
        int e;
        int a;
        lookup(1'b0, 0, d, v);
        check("R8 valid after read", int'(v), 1);
        check({"R3 antilog[0] ", tag}, d, 1);
        lookup(1'b0, m, d, v);
        check({"R3 antilog[m] ", tag}, d, p & ((1 << m) - 1));
        lookup(1'b0, (1 << m) - 1, d, v);
        check({"R5 antilog wrap ", tag}, d, 1);
        lookup(1'b1, 0, d, v);
        check({"R5 log[0] ", tag}, d, 0);
        lookup(1'b1, 2, d, v);
        check({"R4 log[2] ", tag}, d, 1);
        for (int k = 0; k < nrand; k++) begin
            e = $urandom_range((1 << m) - 2, 0);
            a = alpha_pow(m, p, e);
            lookup(1'b0, e, d, v);
            check({"R3 random antilog ", tag}, d, a);
            lookup(1'b1, a, d, v);
            check({"R4 random log ", tag}, d, e);
        end
    endtask

    initial begin
        int n;
        int seed_val;
        int d;
        bit v;
        seed_val = int'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        check("R1 errors after reset", int'({err_degree, err_nonprim}), 0);
        check("R1 rd_valid after reset", int'(rd_valid), 0);

        // m = 13 with a mid-build start and read
        run_build(1'b0, 'h201B, 1'b1, n);
        check("R2 R10 build length m=13", n, (1 << 13) + 2);
        check("R2 no error m=13", int'({err_degree, err_nonprim}), 0);
        table_checks(13, 'h201B, "m13", 12);

        // m = 14
        run_build(1'b1, 'h4443, 1'b0, n);
        check("R2 build length m=14", n, (1 << 14) + 2);
        check("R2 no error m=14", int'({err_degree, err_nonprim}), 0);
        table_checks(14, 'h4443, "m14", 12);

        // wrong degree: m=14 asked with a degree-13 polynomial
        run_build(1'b1, 'h201B, 1'b0, n);
        check("R6 degree error timing (low)", n, 2);
        check("R6 err_degree set", int'(err_degree), 1);
        check("R6 err_nonprim clear", int'(err_nonprim), 0);
        // wrong degree: m=13 asked with a degree-14 polynomial
        run_build(1'b0, 'h4443, 1'b0, n);
        check("R6 degree error timing (high)", n, 2);
        check("R6 err_degree set (high)", int'(err_degree), 1);

        // reducible polynomial x^13 + 1
        run_build(1'b0, 'h2001, 1'b0, n);
        check("R7 nonprim timing", n, 16);
        check("R7 err_nonprim set", int'(err_nonprim), 1);
        check("R7 err_degree clear", int'(err_degree), 0);

        // reset clears flags
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 done cleared", int'(done), 0);
        check("R11 errors cleared", int'({err_degree, err_nonprim}), 0);
        lookup(1'b0, 0, d, v);
        check("R8 read valid after reset while idle", int'(v), 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule